// File: doc/BRIEF.md
# Memory Error Syndrome Capture Register

This block sits beside the error checkers of a shared cache and keeps a record of the first RAM error reported after software last cleared it. Four RAM sources can report errors in any cycle: the tag array, the data array, the snoop tag array and the dirty-state array. Each report carries a 4-bit selector and an 18-bit index. The selector is a way number for most sources and a processor/way pair for the snoop tag array. On the first error the block latches the source's RAM code, the selector and the index, and it sets a sticky valid flag.

After the first error, every cycle that has an error at the captured location raises a repeat counter by one. Every cycle that has an error anywhere else raises an other-error counter by one. Each counter rises at most once per cycle, however many sources report, and stops at its maximum. Software reads the whole state as one 64-bit word. Any write clears the word, whatever data is written.

Top module: `mes_syndrome`

## Requirements
- R1: After reset the read word `reg_rdata` is all zero.
- R2: The first error after reset or clear sets bit 31 (valid). The cycle after the error, the word also shows the source's RAM code in bits 30:24 (tag 0x10, data 0x11, snoop tag 0x12, dirty 0x14), its selector in bits 21:18 and its index in bits 17:0. Source numbering on `err_vld` is bit 0 tag, bit 1 data, bit 2 snoop tag, bit 3 dirty.
- R3: Once valid is set, bits 31:0 do not change until a write, whatever errors are reported.
- R4: If several sources report a first error in the same cycle, the lowest-numbered source is captured (tag, then data, then snoop tag, then dirty). In that case the other-error count in bits 47:40 becomes exactly 1.
- R5: For the snoop tag source the selector is {cpu[1:0], way}, stored in bits 20:18. Bit 21 is forced to 0, and input bit 3 of that selector is ignored, both for capture and for matching.
- R6: While valid is set, a cycle in which the captured source reports an error with the captured selector and index adds one to the repeat count in bits 39:32.
- R7: While valid is set, a cycle with one or more errors that do not match the captured location adds exactly one to the other-error count. A cycle can raise both counts.
- R8: Both counts saturate at 255.
- R9: A cycle with `reg_wr` high clears the whole word on the next cycle. Errors reported in that same cycle are discarded.
- R10: Bits 63:48 and 23:22 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 4 | Per-source error strobe (0 tag, 1 data, 2 snoop tag, 3 dirty) |
| err_sel | input | 16 | Per-source selector, source i at bits 4i+3:4i |
| err_idx | input | 72 | Per-source index, source i at bits 18i+17:18i |
| reg_wr | input | 1 | Register write strobe; clears all state |
| reg_rdata | output | 64 | Syndrome word |

## Verification
Three pairs of functions can fall in the same cycle. A capture can coincide with counting, when several sources report the first error together. A repeat can coincide with an other-error event, when the captured source repeats while another source reports elsewhere. A software clear can coincide with an error report. The bench provokes each pair by driving the pair of events in one cycle. A reference model built from the requirements predicts the word for the next cycle, and a monitor judges the design against that prediction: the priority winner and a single increment, both counters rising by one, and an all-zero word after the clear.

// File: rtl/mes_pkg.sv
package mes_pkg;
   localparam int NSRC   = 4;
   localparam int SEL_W  = 4;
   localparam int IDX_W  = 18;
   localparam int CNT_W  = 8;
   localparam int SRC_W  = 2;

   localparam int SRC_TAG   = 0;
   localparam int SRC_DATA  = 1;
   localparam int SRC_SNOOP = 2;
   localparam int SRC_DIRTY = 3;

   typedef struct packed {
      logic             vld;
      logic [SRC_W-1:0] src;
      logic [SEL_W-1:0] sel;
      logic [IDX_W-1:0] idx;
   } cap_t;

   function automatic logic [6:0] ram_code(input logic [SRC_W-1:0] s);
      case (s)
         2'd0:    ram_code = 7'h10;
         2'd1:    ram_code = 7'h11;
         2'd2:    ram_code = 7'h12;
         default: ram_code = 7'h14;
      endcase
   endfunction
endpackage

// File: rtl/mes_prio_pick.sv
module mes_prio_pick #(
   parameter int N   = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] gnt,
   output logic          any,
   output logic          multi
);
   initial begin
      if (N < 1) $error("mes_prio_pick: N must be at least 1");
   end

   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt = IW'(i);
      end
   end

   assign any   = |req;
   assign multi = |(req & (req - N'(1)));
endmodule

// File: rtl/mes_loc_cmp.sv
module mes_loc_cmp #(
   parameter int SEL_W = 4,
   parameter int IDX_W = 18,
   parameter int SRC_W = 2,
   parameter int MY_SRC = 0
) (
   input  logic             vld,
   input  logic [SEL_W-1:0] sel,
   input  logic [IDX_W-1:0] idx,
   input  logic             cap_vld,
   input  logic [SRC_W-1:0] cap_src,
   input  logic [SEL_W-1:0] cap_sel,
   input  logic [IDX_W-1:0] cap_idx,
   output logic             hit,
   output logic             miss
);
   logic same;
   assign same = (cap_src == SRC_W'(MY_SRC)) && (sel == cap_sel) && (idx == cap_idx);
   assign hit  = vld && cap_vld && same;
   assign miss = vld && !(cap_vld && same);
endmodule

// File: rtl/mes_sat_cnt.sv
module mes_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   initial begin
      if (W < 1) $error("mes_sat_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (inc && q != MAXV)  q <= q + W'(1);
   end

   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q == MAXV && !clr) |=> (q == MAXV));
   p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (q == $past(q) || q == $past(q) + W'(1)));
endmodule

// File: rtl/mes_syndrome.sv
module mes_syndrome
   import mes_pkg::*;
#(
   parameter int SNOOP_SRC = SRC_SNOOP,
   localparam int SELS_W = NSRC * SEL_W,
   localparam int IDXS_W = NSRC * IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   err_vld,
   input  logic [SELS_W-1:0] err_sel,
   input  logic [IDXS_W-1:0] err_idx,
   input  logic              reg_wr,
   output logic [63:0]       reg_rdata
);
   initial begin
      if (IDX_W > 18)  $error("mes_syndrome: index field is 18 bits");
      if (SEL_W != 4)  $error("mes_syndrome: selector field is 4 bits");
      if (CNT_W > 8)   $error("mes_syndrome: counter fields are 8 bits");
      if (SNOOP_SRC >= NSRC) $error("mes_syndrome: bad snoop source");
   end

   logic [SEL_W-1:0] sel_n [NSRC];
   logic [IDX_W-1:0] idx_s [NSRC];
   logic [NSRC-1:0]  hit, miss;
   cap_t             cap_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == SNOOP_SRC) begin : g_snoop
         assign sel_n[i] = {1'b0, err_sel[i*SEL_W +: SEL_W-1]};
      end else begin : g_way
         assign sel_n[i] = err_sel[i*SEL_W +: SEL_W];
      end
      assign idx_s[i] = err_idx[i*IDX_W +: IDX_W];

      mes_loc_cmp #(
         .SEL_W(SEL_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .MY_SRC(i)
      ) u_cmp (
         .vld(err_vld[i]), .sel(sel_n[i]), .idx(idx_s[i]),
         .cap_vld(cap_q.vld), .cap_src(cap_q.src),
         .cap_sel(cap_q.sel), .cap_idx(cap_q.idx),
         .hit(hit[i]), .miss(miss[i])
      );
   end

   logic [SRC_W-1:0] win;
   logic             any_err, multi_err;

   mes_prio_pick #(.N(NSRC)) u_pick (
      .req(err_vld), .gnt(win), .any(any_err), .multi(multi_err)
   );

   logic take;
   assign take = !reg_wr && !cap_q.vld && any_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (reg_wr) begin
         cap_q <= '0;
      end else if (take) begin
         cap_q.vld <= 1'b1;
         cap_q.src <= win;
         cap_q.sel <= sel_n[win];
         cap_q.idx <= idx_s[win];
      end
   end

   logic             rep_inc, oth_inc;
   logic [CNT_W-1:0] rep_q, oth_q;

   assign rep_inc = cap_q.vld && (|hit);
   assign oth_inc = cap_q.vld ? (|miss) : multi_err;

   mes_sat_cnt #(.W(CNT_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .clr(reg_wr), .inc(rep_inc), .q(rep_q)
   );
   mes_sat_cnt #(.W(CNT_W)) u_oth (
      .clk(clk), .rst_n(rst_n), .clr(reg_wr), .inc(oth_inc), .q(oth_q)
   );

   always_comb begin
      reg_rdata        = '0;
      reg_rdata[47:40] = 8'(oth_q);
      reg_rdata[39:32] = 8'(rep_q);
      reg_rdata[31]    = cap_q.vld;
      reg_rdata[30:24] = cap_q.vld ? ram_code(cap_q.src) : 7'h00;
      reg_rdata[21:18] = cap_q.sel;
      reg_rdata[17:0]  = 18'(cap_q.idx);
   end

   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[31] && !reg_wr) |=> $stable(reg_rdata[31:0]));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata == 64'h0));
   p_first_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[31] && !reg_wr && |err_vld) |=> reg_rdata[31]);
   p_snoop_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[30:24] == 7'h12) |-> !reg_rdata[21]);
   always_comb begin
      p_reserved_r10: assert (reg_rdata[63:48] == 16'h0 && reg_rdata[23:22] == 2'b00);
   end
endmodule

// File: tb/mes_syndrome_bench.sv
module mes_syndrome_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  err_vld = '0;
   logic [15:0] err_sel = '0;
   logic [71:0] err_idx = '0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_rdata;

   always #4 clk = ~clk;

   mes_syndrome u_mes_syndrome (
      .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_sel(err_sel),
      .err_idx(err_idx), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [63:0] q_exp[$];
   string       q_tag[$];

   // reference model state
   bit        m_vld;
   bit [1:0]  m_src;
   bit [3:0]  m_sel;
   bit [17:0] m_idx;
   int        m_rep, m_oth;

   function automatic bit [6:0] code(input bit [1:0] s);
      return (s == 0) ? 7'h10 : (s == 1) ? 7'h11 : (s == 2) ? 7'h12 : 7'h14;
   endfunction

   function automatic logic [63:0] model_word();
      logic [63:0] w = '0;
      w[47:40] = 8'(m_oth);
      w[39:32] = 8'(m_rep);
      w[31]    = m_vld;
      w[30:24] = m_vld ? code(m_src) : 7'h0;
      w[21:18] = m_sel;
      w[17:0]  = m_idx;
      return w;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, advance model, push expectation
   task automatic drive(input logic [3:0] v, input logic [15:0] s,
                        input logic [71:0] x, input logic w, input string tag);
      bit [3:0] sn [4];
      bit [17:0] xi [4];
      bit hit, miss;
      int cnt;
      @(negedge clk);
      err_vld = v; err_sel = s; err_idx = x; reg_wr = w;
      for (int i = 0; i < 4; i++) begin
         sn[i] = s[i*4 +: 4];
         if (i == 2) sn[i][3] = 1'b0;
         xi[i] = x[i*18 +: 18];
      end
      if (w) begin
         m_vld = 0; m_src = 0; m_sel = 0; m_idx = 0; m_rep = 0; m_oth = 0;
      end else if (!m_vld) begin
         cnt = 0;
         for (int i = 3; i >= 0; i--) if (v[i]) begin
            cnt++; m_src = 2'(i); m_sel = sn[i]; m_idx = xi[i];
         end
         if (cnt > 0) m_vld = 1;
         if (cnt > 1 && m_oth < 255) m_oth++;
      end else begin
         hit = 0; miss = 0;
         for (int i = 0; i < 4; i++) if (v[i]) begin
            if (i == int'(m_src) && sn[i] == m_sel && xi[i] == m_idx) hit = 1;
            else miss = 1;
         end
         if (hit && m_rep < 255) m_rep++;
         if (miss && m_oth < 255) m_oth++;
      end
      q_exp.push_back(model_word());
      q_tag.push_back(tag);
   endtask

   task automatic idle(input string tag);
      drive(4'h0, 16'h0, 72'h0, 1'b0, tag);
   endtask

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk); #2;
         if (q_exp.size() > 0) begin
            logic [63:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, reg_rdata, e);
            check("R10 reserved", {reg_rdata[63:48], 14'h0, reg_rdata[23:22]}, 32'h0);
         end
      end
   end

   function automatic logic [71:0] idx4(input bit [17:0] a, b, c, d);
      return {d, c, b, a};
   endfunction

   initial begin
      #20;
      checks++;
      if (reg_rdata !== 64'h0) begin errors++; $display("FAIL R1 actual %h expected 0", reg_rdata); end
      @(negedge clk); rst_n = 1'b1;
      idle("R1 idle after reset");

      // single data-array error
      drive(4'b0010, 16'h0050, idx4(0, 18'h00123, 0, 0), 0, "R2 data capture");
      drive(4'b0010, 16'h0050, idx4(0, 18'h00123, 0, 0), 0, "R6 repeat");
      drive(4'b0010, 16'h0050, idx4(0, 18'h00124, 0, 0), 0, "R7 other idx");
      drive(4'b1101, 16'h3F29, idx4(1, 2, 3, 4), 0, "R7 three sources once");
      drive(4'b1010, 16'h0050, idx4(0, 18'h00123, 0, 7), 0, "R7 R6 same cycle");
      drive(4'b0100, 16'h0500, idx4(0, 0, 9, 0), 0, "R3 fields held");
      drive(4'b0000, 16'h0, 72'h0, 1, "R9 clear");
      idle("R9 stays clear");

      // all four at once
      drive(4'b1111, 16'h4321, idx4(18'h3FFFF, 5, 6, 7), 0, "R4 all four tag wins");
      drive(4'b1111, 16'h4321, idx4(5, 5, 6, 7), 1, "R9 write beats error");
      drive(4'b1010, 16'h9060, idx4(0, 18'h2AAAA, 0, 1), 0, "R4 data over dirty");
      drive(4'b0, 16'h0, 72'h0, 1, "R9 clear");

      // snoop selector with bit 3 set
      drive(4'b0100, 16'h0F00, idx4(0, 0, 18'h00ABC, 0), 0, "R5 snoop capture");
      drive(4'b0100, 16'h0700, idx4(0, 0, 18'h00ABC, 0), 0, "R5 snoop match ignores bit3");
      drive(4'b0, 16'h0, 72'h0, 1, "R9 clear");
      drive(4'b1000, 16'hA000, idx4(0, 0, 0, 18'h1F0F0), 0, "R2 dirty capture");

      // saturation
      for (int k = 0; k < 260; k++) begin
         drive(4'b1001, 16'hA005, idx4(1, 0, 0, 18'h1F0F0), 0, "R8 saturate");
      end
      idle("R8 held at max");
      drive(4'b0, 16'h0, 72'h0, 1, "R9 clear after sat");
      idle("R1 R9 final");
      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (200000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog actual timeout expected finish");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule